// File: doc/BRIEF.md
# SPI Controller Register Bank with FIFO Control

This block is the register file that sits between a 16-bit peripheral bus and an SPI shift engine. Software uses it to configure the engine: word length, clock phase and polarity, rate, idle and forced output level, and master or slave role. It queues words for transmission and collects received words. It also decides how the transmit and receive queues are used. Each queue is either a four-entry FIFO or a single overwritable stage, and the choice is made by a two-bit queue mode. The engine takes words over a valid/take handshake and returns each completed word with a one-cycle strobe.

Words of up to 32 bits travel through two 16-bit data ports. In 32-bit mode software writes the high half first, then the low half, and the write to the low half queues the word. Reading the low half pops the received word. The high half of that word can then be read from the other port. A sticky event flag records each completed word and raises the interrupt line when its mask allows. Any write to the flag-clear address clears it. Two DMA request lines follow one of two policies. In the low-priority policy a request drops on each acknowledge. In the high-priority policy a request holds until its queue is full (transmit) or empty (receive).

Switching the block off is graceful in master mode: the engine keeps running until queued and in-flight data are gone, and then all data state is cleared. A soft-reset bit clears the data state at once but keeps the engine clock request high. Neither path touches the two control registers.

Top module: `spi_csr_bank`

## Requirements
- R1: After reset all five registers read 0, and irq, both DMA requests, eng_run and eng_tx_valid are low.
- R2: In 32-bit mode, a write to 0x2 queues {last value written to 0x4, written value} as one transmit word. In other modes the high half of the word is 0.
- R3: The transmit FIFO holds 4 words in order. In modes 0 and 2, control0 bit 3 reads 1 while it holds 4 words, and a write to 0x2 while full is dropped.
- R4: A read of 0x2 returns the receive head and pops it. A later read of 0x4 returns the popped word's upper half in 32-bit mode. In 8- and 9-bit modes, bits 15:8 of the 0x2 read repeat those of the previously popped value.
- R5: Control0 bit 4 sets on each completed received word. irq equals that bit ANDed with mask bit 2. A write of any value to 0x6 clears the bit, and 0x6 always reads 0.
- R6: In queue modes 0 and 1, eng_tx_valid stays low while the receive FIFO holds 4 words. Control1 bit 3 (busy) reads eng_tx_valid OR eng_shift_busy.
- R7: In queue modes 1 and 3, the transmit side is one stage. A write while it is occupied replaces the word, and control0 bit 3 stays 0.
- R8: In queue modes 2 and 3, the receive side is one stage. A new word replaces the held one, and transmission is never stalled by it.
- R9: Clearing enable (control0 bit 0) in master mode (bit 7 = 0) keeps eng_run high until the transmit queue is empty and eng_shift_busy is low. After that, all data state clears. In slave mode eng_run drops at once. Data writes while enable is 0 are ignored, and the control registers keep their values.
- R10: With soft reset (control0 bit 1) set, eng_run is low, eng_clk_en is high, and queues, held words and the event flag are cleared.
- R11: In low priority (control1 bit 2 = 0), the transmit request rises when the transmit FIFO is empty and the receive request rises when the receive FIFO is full. Each request drops on the cycle after its acknowledge.
- R12: In high priority, a raised transmit request stays high through acknowledges until the FIFO is full. A raised receive request stays high until that FIFO is empty.
- R13: Control0 layout: bit 0 enable, 1 soft reset, 2 mask, 3 tx-full (read-only), 4 event (read-only), 6:5 word length (00 = 8, 01 = 16, 10 = 32, 11 = 9 bits), 7 slave, 8 phase, 9 polarity, 11:10 rate, 12 idle level, 13 force level, 14 select enable.
- R14: Control1 layout: bits 1:0 queue mode, 2 priority, 3 busy (read-only), 4 first-bit value for 9-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data (combinational) |
| eng_run | output | 1 | Engine may run |
| eng_clk_en | output | 1 | Engine clock request |
| eng_slave | output | 1 | Slave role |
| eng_wlen | output | 2 | Word length code |
| eng_cpha | output | 1 | Clock phase |
| eng_cpol | output | 1 | Clock polarity |
| eng_rate | output | 2 | Rate select |
| eng_idle_lvl | output | 1 | Idle data-out level |
| eng_force | output | 1 | Force data-out level |
| eng_sel_en | output | 1 | Slave select honoured |
| eng_bit9 | output | 1 | First bit value in 9-bit mode |
| eng_tx_valid | output | 1 | Transmit word offered |
| eng_tx_data | output | 2*REG_W | Offered word |
| eng_tx_take | input | 1 | Engine takes offered word |
| eng_rx_valid | input | 1 | Completed word strobe |
| eng_rx_data | input | 2*REG_W | Completed received word |
| eng_shift_busy | input | 1 | Shift register holds data |
| irq | output | 1 | Masked interrupt |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_tx_ack | input | 1 | Transmit DMA acknowledge |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_rx_ack | input | 1 | Receive DMA acknowledge |

## Verification
The bench targets the shutdown window. It writes data while draining and then checks that eng_run falls only once the last word has left the shift register. A design that cleared the queue at once would lose words, and one that accepted writes while off would resend them after the next enable. It checks the overwrite stages, since a design that treated them as FIFOs would send the older word. It also checks the stale upper byte in 8-bit reads, which a design zeroing it would get wrong. It separates the two DMA policies by counting acknowledges: a high-priority request must survive three acknowledges and fall only after the fourth fills the queue.

// File: rtl/spi_csr_pkg.sv
package spi_csr_pkg;
    localparam logic [3:0] ADDR_C0  = 4'h0;
    localparam logic [3:0] ADDR_LO  = 4'h2;
    localparam logic [3:0] ADDR_HI  = 4'h4;
    localparam logic [3:0] ADDR_CLR = 4'h6;
    localparam logic [3:0] ADDR_C1  = 4'h8;
    localparam int         BYTE_W   = 8;

    typedef enum logic [1:0] {
        WL_8  = 2'b00,
        WL_16 = 2'b01,
        WL_32 = 2'b10,
        WL_9  = 2'b11
    } wlen_e;

    typedef enum logic [1:0] {
        FM_BOTH    = 2'b00,
        FM_RX_ONLY = 2'b01,
        FM_TX_ONLY = 2'b10,
        FM_NONE    = 2'b11
    } fmode_e;

    typedef struct packed {
        logic       sel_en;
        logic       force_lvl;
        logic       idle_lvl;
        logic [1:0] rate;
        logic       cpol;
        logic       cpha;
        logic       slave;
        wlen_e      wlen;
        logic       mask;
        logic       soft_rst;
        logic       enable;
    } ctrl0_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          single,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    logic [CW-1:0] limit;
    logic          do_pop;
    logic          do_push;

    always_comb begin
        st_d    = st_q;
        limit   = single ? CW'(1) : CW'(DEPTH);
        empty   = (st_q.cnt == '0);
        full    = (st_q.cnt >= limit);
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        if (do_pop) begin
            st_d.rp = step(st_q.rp);
        end
        if (do_push) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp           = step(st_q.wp);
        end else if (push && single) begin
            st_d.mem[st_q.rp] = wdata;
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        if (clear) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end
        head  = st_q.mem[st_q.rp];
        count = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_dma_line.sv
module spi_dma_line (
    input  logic clk,
    input  logic rst_n,
    input  logic allow,
    input  logic high_prio,
    input  logic trigger,
    input  logic done,
    input  logic ack,
    output logic req
);
    logic req_d, req_q;

    always_comb begin
        if (!allow)     req_d = 1'b0;
        else if (req_q) req_d = !(high_prio ? done : ack);
        else            req_d = trigger;
        req = req_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end
endmodule

// File: rtl/spi_csr_bank.sv
module spi_csr_bank
    import spi_csr_pkg::*;
#(
    parameter int  REG_W      = 16,
    parameter int  FIFO_DEPTH = 4,
    localparam int WORD_W     = 2 * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              eng_run,
    output logic              eng_clk_en,
    output logic              eng_slave,
    output logic [1:0]        eng_wlen,
    output logic              eng_cpha,
    output logic              eng_cpol,
    output logic [1:0]        eng_rate,
    output logic              eng_idle_lvl,
    output logic              eng_force,
    output logic              eng_sel_en,
    output logic              eng_bit9,
    output logic              eng_tx_valid,
    output logic [WORD_W-1:0] eng_tx_data,
    input  logic              eng_tx_take,
    input  logic              eng_rx_valid,
    input  logic [WORD_W-1:0] eng_rx_data,
    input  logic              eng_shift_busy,
    output logic              irq,
    output logic              dma_tx_req,
    input  logic              dma_tx_ack,
    output logic              dma_rx_req,
    input  logic              dma_rx_ack
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        ctrl0_t            c0;
        fmode_e            fmode;
        logic              prio;
        logic              ninth;
        logic [REG_W-1:0]  hi_stage;
        logic [WORD_W-1:0] rx_hold;
        logic              evt;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic              wr_any, rd_any, live, flush;
    logic              tx_single, rx_single;
    logic              tx_push, tx_pop, rx_push, rx_pop;
    logic [WORD_W-1:0] tx_word, tx_head, rx_head, rx_merged;
    logic              tx_empty, tx_full, rx_empty, rx_full, rx_room;
    logic [CW-1:0]     tx_count, rx_count;
    logic              srst_bit;
    logic [1:0]        fifo_mode;
    logic              narrow;
    logic [REG_W-1:0]  rd_c0, rd_c1;
    logic              wdata_unused;

    assign wdata_unused = ^{bus_wdata[REG_W-1:15], bus_wdata[4:3]};
    assign srst_bit     = st_q.c0.soft_rst;
    assign fifo_mode    = st_q.fmode;

    spi_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .clear(flush), .single(tx_single),
        .push(tx_push), .wdata(tx_word), .pop(tx_pop), .head(tx_head),
        .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    spi_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .clear(flush), .single(rx_single),
        .push(rx_push), .wdata(eng_rx_data), .pop(rx_pop), .head(rx_head),
        .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    spi_dma_line tx_dma_i (
        .clk(clk), .rst_n(rst_n), .allow(live && !tx_single),
        .high_prio(st_q.prio), .trigger(tx_empty), .done(tx_full),
        .ack(dma_tx_ack), .req(dma_tx_req)
    );

    spi_dma_line rx_dma_i (
        .clk(clk), .rst_n(rst_n), .allow(eng_run && !rx_single),
        .high_prio(st_q.prio), .trigger(rx_full), .done(rx_empty),
        .ack(dma_rx_ack), .req(dma_rx_req)
    );

    // datapath and control decode
    always_comb begin
        wr_any    = bus_sel && bus_wr;
        rd_any    = bus_sel && !bus_wr;
        tx_single = st_q.fmode[0];
        rx_single = st_q.fmode[1];
        live      = st_q.c0.enable && !st_q.c0.soft_rst;
        eng_run   = !st_q.c0.soft_rst &&
                    (st_q.c0.enable || (!st_q.c0.slave && (!tx_empty || eng_shift_busy)));
        flush     = !eng_run;
        eng_clk_en = eng_run || st_q.c0.soft_rst;

        tx_word = (st_q.c0.wlen == WL_32) ? {st_q.hi_stage, bus_wdata}
                                          : {{REG_W{1'b0}}, bus_wdata};
        tx_push = wr_any && (bus_addr == ADDR_LO) && live;
        rx_room = !rx_full || rx_single;
        eng_tx_valid = eng_run && !tx_empty && rx_room;
        eng_tx_data  = tx_head;
        tx_pop  = eng_tx_take && eng_tx_valid;
        rx_push = eng_rx_valid && eng_run;
        rx_pop  = rd_any && (bus_addr == ADDR_LO);

        narrow = (st_q.c0.wlen == WL_8) || (st_q.c0.wlen == WL_9);
        rx_merged[BYTE_W-1:0]      = rx_head[BYTE_W-1:0];
        rx_merged[REG_W-1:BYTE_W]  = narrow ? st_q.rx_hold[REG_W-1:BYTE_W]
                                            : rx_head[REG_W-1:BYTE_W];
        rx_merged[WORD_W-1:REG_W]  = (st_q.c0.wlen == WL_32) ? rx_head[WORD_W-1:REG_W]
                                                             : st_q.rx_hold[WORD_W-1:REG_W];

        rd_c0        = '0;
        rd_c0[0]     = st_q.c0.enable;
        rd_c0[1]     = st_q.c0.soft_rst;
        rd_c0[2]     = st_q.c0.mask;
        rd_c0[3]     = tx_full && !tx_single;
        rd_c0[4]     = st_q.evt;
        rd_c0[6:5]   = st_q.c0.wlen;
        rd_c0[7]     = st_q.c0.slave;
        rd_c0[8]     = st_q.c0.cpha;
        rd_c0[9]     = st_q.c0.cpol;
        rd_c0[11:10] = st_q.c0.rate;
        rd_c0[12]    = st_q.c0.idle_lvl;
        rd_c0[13]    = st_q.c0.force_lvl;
        rd_c0[14]    = st_q.c0.sel_en;

        rd_c1      = '0;
        rd_c1[1:0] = st_q.fmode;
        rd_c1[2]   = st_q.prio;
        rd_c1[3]   = eng_tx_valid || eng_shift_busy;
        rd_c1[4]   = st_q.ninth;

        unique case (bus_addr)
            ADDR_C0: bus_rdata = rd_c0;
            ADDR_LO: bus_rdata = rx_empty ? st_q.rx_hold[REG_W-1:0] : rx_merged[REG_W-1:0];
            ADDR_HI: bus_rdata = st_q.rx_hold[WORD_W-1:REG_W];
            ADDR_C1: bus_rdata = rd_c1;
            default: bus_rdata = '0;
        endcase

        irq          = st_q.evt && st_q.c0.mask;
        eng_slave    = st_q.c0.slave;
        eng_wlen     = st_q.c0.wlen;
        eng_cpha     = st_q.c0.cpha;
        eng_cpol     = st_q.c0.cpol;
        eng_rate     = st_q.c0.rate;
        eng_idle_lvl = st_q.c0.idle_lvl;
        eng_force    = st_q.c0.force_lvl;
        eng_sel_en   = st_q.c0.sel_en;
        eng_bit9     = st_q.ninth;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (wr_any && bus_addr == ADDR_C0) begin
            st_d.c0.enable    = bus_wdata[0];
            st_d.c0.soft_rst  = bus_wdata[1];
            st_d.c0.mask      = bus_wdata[2];
            st_d.c0.wlen      = wlen_e'(bus_wdata[6:5]);
            st_d.c0.slave     = bus_wdata[7];
            st_d.c0.cpha      = bus_wdata[8];
            st_d.c0.cpol      = bus_wdata[9];
            st_d.c0.rate      = bus_wdata[11:10];
            st_d.c0.idle_lvl  = bus_wdata[12];
            st_d.c0.force_lvl = bus_wdata[13];
            st_d.c0.sel_en    = bus_wdata[14];
        end
        if (wr_any && bus_addr == ADDR_C1) begin
            st_d.fmode = fmode_e'(bus_wdata[1:0]);
            st_d.prio  = bus_wdata[2];
            st_d.ninth = bus_wdata[4];
        end
        if (wr_any && bus_addr == ADDR_HI && live) begin
            st_d.hi_stage = bus_wdata;
        end
        if (rx_pop && !rx_empty) begin
            st_d.rx_hold = rx_merged;
        end
        if (rx_push) begin
            st_d.evt = 1'b1;
        end else if (wr_any && bus_addr == ADDR_CLR) begin
            st_d.evt = 1'b0;
        end
        if (flush) begin
            st_d.hi_stage = '0;
            st_d.rx_hold  = '0;
            st_d.evt      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_csr_bank_chk.sv
module spi_csr_bank_chk
    import spi_csr_pkg::*;
#(
    parameter int  DEPTH = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [3:0]    bus_addr,
    input logic          eng_rx_valid,
    input logic          irq,
    input logic          eng_run,
    input logic          eng_tx_valid,
    input logic          srst_bit,
    input logic [1:0]    fifo_mode,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count
);
    a_r5_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_CLR && !eng_rx_valid) |=> !irq);

    a_r10_srst_empties: assert property (@(posedge clk) disable iff (!rst_n)
        srst_bit |=> (tx_count == '0 && rx_count == '0));

    a_r3_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CW'(DEPTH));

    a_r6_rx_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode[1] && rx_count == CW'(DEPTH)) |-> !eng_tx_valid);

    a_r9_drain_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_run && tx_count > CW'(1) && !(bus_sel && bus_wr && bus_addr == ADDR_C0))
        |=> eng_run);

    a_r1_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_run |=> (tx_count == '0));
endmodule

bind spi_csr_bank spi_csr_bank_chk #(.DEPTH(4)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .eng_rx_valid(eng_rx_valid), .irq(irq),
    .eng_run(eng_run), .eng_tx_valid(eng_tx_valid), .srst_bit(srst_bit),
    .fifo_mode(fifo_mode), .tx_count(tx_count), .rx_count(rx_count)
);

// File: tb/spi_csr_bank_tb_top.sv
`timescale 1ns/1ps
module spi_csr_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        eng_run, eng_clk_en, eng_slave, eng_cpha, eng_cpol;
    logic [1:0]  eng_wlen, eng_rate;
    logic        eng_idle_lvl, eng_force, eng_sel_en, eng_bit9;
    logic        eng_tx_valid, eng_tx_take = 1'b0;
    logic [31:0] eng_tx_data, eng_rx_data = '0;
    logic        eng_rx_valid = 1'b0, eng_shift_busy = 1'b0;
    logic        irq, dma_tx_req, dma_rx_req;
    logic        dma_tx_ack = 1'b0, dma_rx_ack = 1'b0;
    int          n_chk = 0, n_fail = 0;
    logic [15:0] v;

    always #4 clk = ~clk;

    spi_csr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_run(eng_run), .eng_clk_en(eng_clk_en), .eng_slave(eng_slave),
        .eng_wlen(eng_wlen), .eng_cpha(eng_cpha), .eng_cpol(eng_cpol),
        .eng_rate(eng_rate), .eng_idle_lvl(eng_idle_lvl), .eng_force(eng_force),
        .eng_sel_en(eng_sel_en), .eng_bit9(eng_bit9), .eng_tx_valid(eng_tx_valid),
        .eng_tx_data(eng_tx_data), .eng_tx_take(eng_tx_take),
        .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
        .eng_shift_busy(eng_shift_busy), .irq(irq), .dma_tx_req(dma_tx_req),
        .dma_tx_ack(dma_tx_ack), .dma_rx_req(dma_rx_req), .dma_rx_ack(dma_rx_ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic ack = 1'b0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; dma_tx_ack = ack;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; dma_tx_ack = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d, input logic ack = 1'b0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; dma_rx_ack = ack;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; dma_rx_ack = 1'b0;
    endtask

    task automatic rx_word(input logic [31:0] d);
        @(negedge clk);
        eng_rx_valid = 1'b1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_valid = 1'b0;
    endtask

    task automatic take();
        @(negedge clk);
        eng_tx_take = 1'b1;
        @(negedge clk);
        eng_tx_take = 1'b0;
    endtask

    task automatic cleanup(input logic [15:0] c1);
        wr(4'h0, 16'h0002);
        wr(4'h8, c1);
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_reset();
        chk("R1 ctrl0", {16'h0, dut_rd(4'h0)}, 32'h0);
        chk("R1 irq/dma/run/tx_valid", {irq, dma_tx_req, dma_rx_req, eng_run, eng_tx_valid}, 0);
        rd(4'h2, v); chk("R1 data-low", v, 0);
        rd(4'h4, v); chk("R1 data-high", v, 0);
        rd(4'h6, v); chk("R1 clear reg", v, 0);
        rd(4'h8, v); chk("R1 R14 ctrl1", v, 0);
    endtask

    function automatic logic [15:0] dut_rd(input logic [3:0] a);
        return (a == 4'h0) ? bus_rdata : 16'hxxxx;
    endfunction

    task automatic t_tx32();
        cleanup(16'h0000);
        wr(4'h0, 16'h0040);
        wr(4'h0, 16'h0041);
        wr(4'h4, 16'hABCD);
        wr(4'h2, 16'h1234);
        chk("R2 tx valid", eng_tx_valid, 1);
        chk("R2 32-bit word", eng_tx_data, 32'hABCD_1234);
        chk("R13 wlen out", eng_wlen, 2'b10);
        take();
        chk("R2 tx drained", eng_tx_valid, 0);
    endtask

    task automatic t_txfull();
        cleanup(16'h0000);
        wr(4'h0, 16'h0001);
        for (int i = 1; i <= 5; i++) wr(4'h2, 16'(i));
        rd(4'h0, v); chk("R3 R13 full bit", v, 16'h0009);
        for (int i = 1; i <= 4; i++) begin
            chk("R3 order", eng_tx_data, 32'(i));
            take();
        end
        chk("R3 fifth dropped", eng_tx_valid, 0);
    endtask

    task automatic t_rx_irq();
        cleanup(16'h0000);
        wr(4'h0, 16'h0040);
        wr(4'h0, 16'h0041);
        rx_word(32'h1111_2222);
        rd(4'h0, v); chk("R5 event bit", v, 16'h0051);
        chk("R5 irq masked", irq, 0);
        wr(4'h0, 16'h0045);
        chk("R5 irq unmasked", irq, 1);
        rd(4'h2, v); chk("R4 low half", v, 16'h2222);
        rd(4'h4, v); chk("R4 high half", v, 16'h1111);
        wr(4'h6, 16'h5A5A);
        chk("R5 irq cleared", irq, 0);
        rd(4'h0, v); chk("R5 event cleared", v, 16'h0045);
        rd(4'h6, v); chk("R5 clear reads 0", v, 0);
        wr(4'h0, 16'h0005);
        rx_word(32'h0000_99AB);
        rd(4'h2, v); chk("R4 stale upper byte", v, 16'h22AB);
    endtask

    task automatic t_flow();
        cleanup(16'h0000);
        wr(4'h0, 16'h0001);
        for (int i = 1; i <= 4; i++) rx_word(32'(i));
        wr(4'h2, 16'h0077);
        chk("R6 stalled when rx full", eng_tx_valid, 0);
        rd(4'h8, v); chk("R6 busy low", v, 16'h0000);
        rd(4'h2, v); chk("R6 rx head", v, 16'h0001);
        chk("R6 resumes", eng_tx_valid, 1);
        rd(4'h8, v); chk("R6 busy high", v, 16'h0008);
    endtask

    task automatic t_tx_single();
        cleanup(16'h0001);
        wr(4'h0, 16'h0001);
        wr(4'h2, 16'h0011);
        wr(4'h2, 16'h0022);
        chk("R7 overwrite", eng_tx_data, 32'h22);
        rd(4'h0, v); chk("R7 full bit stays 0", v, 16'h0001);
        take();
        chk("R7 single entry", eng_tx_valid, 0);
    endtask

    task automatic t_rx_single();
        cleanup(16'h0002);
        wr(4'h0, 16'h0001);
        rx_word(32'h33);
        rx_word(32'h44);
        wr(4'h2, 16'h0055);
        chk("R8 no stall", eng_tx_valid, 1);
        rd(4'h2, v); chk("R8 newest kept", v, 16'h0044);
    endtask

    task automatic t_drain();
        cleanup(16'h0002);
        wr(4'h0, 16'h0001);
        wr(4'h2, 16'h00A1);
        wr(4'h2, 16'h00A2);
        wr(4'h0, 16'h0000);
        chk("R9 run during drain", eng_run, 1);
        wr(4'h2, 16'h00A3);
        take();
        chk("R9 second word", eng_tx_data, 32'hA2);
        eng_shift_busy = 1'b1;
        take();
        chk("R9 held by shifter", {eng_run, eng_tx_valid}, 2'b10);
        @(negedge clk);
        eng_shift_busy = 1'b0;
        #1 chk("R9 run drops", eng_run, 0);
        @(negedge clk);
        wr(4'h0, 16'h0001);
        chk("R9 write while off ignored", eng_tx_valid, 0);
        rd(4'h8, v); chk("R9 ctrl1 kept", v, 16'h0002);
        wr(4'h0, 16'h0080);
        wr(4'h0, 16'h0081);
        wr(4'h2, 16'h00B1);
        wr(4'h0, 16'h0080);
        chk("R9 slave stops at once", eng_run, 0);
        wr(4'h0, 16'h0081);
        chk("R9 slave queue cleared", eng_tx_valid, 0);
    endtask

    task automatic t_softrst();
        cleanup(16'h0000);
        wr(4'h0, 16'h0001);
        rx_word(32'h55);
        wr(4'h2, 16'h0066);
        wr(4'h0, 16'h0003);
        chk("R10 run/clk", {eng_run, eng_clk_en}, 2'b01);
        rd(4'h0, v); chk("R10 event cleared", v, 16'h0003);
        wr(4'h0, 16'h0001);
        chk("R10 tx flushed", eng_tx_valid, 0);
        rd(4'h2, v); chk("R10 rx flushed", v, 0);
    endtask

    task automatic t_dma_low();
        cleanup(16'h0000);
        wr(4'h0, 16'h0001);
        @(negedge clk); @(negedge clk);
        chk("R11 tx req on empty", dma_tx_req, 1);
        wr(4'h2, 16'h0010, 1'b1);
        chk("R11 tx req drops on ack", dma_tx_req, 0);
        for (int i = 0; i < 4; i++) rx_word(32'h20 + 32'(i));
        @(negedge clk);
        chk("R11 rx req on full", dma_rx_req, 1);
        rd(4'h2, v, 1'b1);
        chk("R11 rx req drops on ack", dma_rx_req, 0);
    endtask

    task automatic t_dma_high();
        cleanup(16'h0004);
        wr(4'h0, 16'h0001);
        @(negedge clk); @(negedge clk);
        chk("R12 tx req raised", dma_tx_req, 1);
        for (int i = 0; i < 3; i++) wr(4'h2, 16'(i), 1'b1);
        chk("R12 held through acks", dma_tx_req, 1);
        wr(4'h2, 16'h0003, 1'b1);
        @(negedge clk);
        chk("R12 drops when full", dma_tx_req, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx32();
        t_txfull();
        t_rx_irq();
        t_flow();
        t_tx_single();
        t_rx_single();
        t_drain();
        t_softrst();
        t_dma_low();
        t_dma_high();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule